// File: doc/BRIEF.md
# Four-Channel DC-Blocking High-Pass Filter

This block removes the DC offset from a stream of 24-bit signed audio samples that is shared by four channels. Each accepted sample runs through a first-order recursive high-pass section. Its cut-off sits near 1 Hz at a 48 kHz sample rate and scales with the sample rate. The result is rounded, saturated and registered, so it appears one clock after the sample was accepted. Each channel keeps its own previous input and previous output. Channels are served in a fixed rotation that restarts at channel 0.

An active-low power-down input clears all filter history and the channel rotation, and silences the output. The filter/bypass choice is taken from the enable request only while power-down is asserted. While the block runs, the request is ignored, so the DC level of the output cannot jump in the middle of a stream. In bypass mode each sample reaches the output unchanged, with the same one-cycle latency as the filtered path.

Top module: `dc_block_hpf`

## Requirements
- R1: While `pwr_dn_n` is low at a rising clock edge, that edge drives `out_valid` to 0 and `out_data` to 0.
- R2: The mode register follows `hpf_en_req` on every edge where `pwr_dn_n` is low. On edges where `pwr_dn_n` is high it keeps its value. After reset the mode is bypass (0). A mode of 1 means filtered.
- R3: In bypass mode an accepted sample appears unchanged on `out_data` one clock later, with `out_valid` = 1.
- R4: In filtered mode each channel holds a scaled state s, which is the output times 256, in 34-bit signed form. For each accepted sample x with previous input xp, the new state is s' = clamp34((x−xp)·256 + floor((A·s + 2^23) / 2^24)), where A = 16775020 (unsigned, 24 fraction bits). The output one clock later is clamp24(floor((s'+128)/256)).
- R5: Accepted samples are assigned to channels 0,1,2,3,0,... in that order. `out_ch` gives the channel of the sample on `out_data`. The rotation restarts at 0 after any power-down.
- R6: Each channel's xp and s registers change only on samples accepted for that channel.
- R7: The filtered output saturates to the range −8388608 to 8388607 and does not wrap.
- R8: Power-down clears xp and s of every channel to 0. The first filtered sample x after power-down therefore yields x (unless it saturates).
- R9: A cycle with `in_valid` low, or with `pwr_dn_n` low, is not accepted. The next cycle has `out_valid` = 0, and neither the channel rotation nor any filter state advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn_n | input | 1 | Active-low power-down; clears the filter and latches the mode |
| hpf_en_req | input | 1 | Mode request: 1 filtered, 0 bypass; sampled only in power-down |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 24 | Signed input sample |
| out_valid | output | 1 | Output strobe, one clock after an accepted sample |
| out_ch | output | 2 | Channel of the current output sample |
| out_data | output | 24 | Signed filtered or bypassed sample |

## Verification
A change of the enable request can coincide with the release of power-down. The bench provokes this by flipping `hpf_en_req` in the same cycle that `pwr_dn_n` rises, and again in the middle of streams. It judges the outcome by whether every following output still matches the mode that was held at the last low edge. Power-down can also arrive while a sample is being strobed. The bench holds `in_valid` high through a power-down and checks that this sample is dropped. It also checks that the first samples afterwards start on channel 0 from cleared history.

// File: rtl/hpf_pkg.sv
package hpf_pkg;
  localparam int SMP_W   = 24;
  localparam int GUARD_W = 8;
  localparam int HEAD_W  = 2;
  localparam int ACC_W   = SMP_W + GUARD_W + HEAD_W;
  localparam int COEF_W  = 24;
  localparam int WIDE_W  = ACC_W + COEF_W + 2;
  localparam logic [COEF_W-1:0] COEF_DEF = 24'd16775020;

  typedef logic signed [SMP_W-1:0]  smp_t;
  typedef logic signed [ACC_W-1:0]  acc_t;
  typedef logic signed [WIDE_W-1:0] wide_t;

  // clamp a wide value to the accumulator range
  function automatic acc_t clamp_acc(wide_t v);
    wide_t hi, lo;
    hi = (wide_t'(1) <<< (ACC_W-1)) - wide_t'(1);
    lo = -(wide_t'(1) <<< (ACC_W-1));
    if (v > hi)      return acc_t'(hi);
    else if (v < lo) return acc_t'(lo);
    else             return acc_t'(v);
  endfunction

  // one recursion step on the scaled state
  function automatic acc_t next_state(smp_t x, smp_t xp, acc_t s,
                                      logic [COEF_W-1:0] a);
    wide_t diff, prod, sum;
    diff = wide_t'(x) - wide_t'(xp);
    prod = wide_t'(s) * wide_t'($signed({1'b0, a}));
    prod = (prod + (wide_t'(1) <<< (COEF_W-1))) >>> COEF_W;
    sum  = (diff <<< GUARD_W) + prod;
    return clamp_acc(sum);
  endfunction

  // round away the guard bits and clamp to the sample range
  function automatic smp_t state_to_out(acc_t s);
    wide_t r, hi, lo;
    r  = (wide_t'(s) + (wide_t'(1) <<< (GUARD_W-1))) >>> GUARD_W;
    hi = (wide_t'(1) <<< (SMP_W-1)) - wide_t'(1);
    lo = -(wide_t'(1) <<< (SMP_W-1));
    if (r > hi)      return smp_t'(hi);
    else if (r < lo) return smp_t'(lo);
    else             return smp_t'(r);
  endfunction
endpackage

// File: rtl/hpf_mode_latch.sv
module hpf_mode_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_dn_n,
  input  logic en_req,
  output logic mode_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_en <= 1'b0;
    else if (!pwr_dn_n) mode_en <= en_req;
  end
endmodule

// File: rtl/hpf_chan_seq.sv
module hpf_chan_seq #(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            adv,
  output logic [CH_W-1:0] ch_idx
);
  localparam logic [CH_W-1:0] LAST = CH_W'(NUM_CH-1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ch_idx <= '0;
    else if (clr)    ch_idx <= '0;
    else if (adv)    ch_idx <= (ch_idx == LAST) ? '0 : ch_idx + CH_W'(1);
  end
endmodule

// File: rtl/hpf_state_bank.sv
module hpf_state_bank
  import hpf_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            wr_en,
  input  logic [CH_W-1:0] sel_ch,
  input  smp_t            wr_x,
  input  acc_t            wr_s,
  output smp_t            rd_x,
  output acc_t            rd_s
);
  smp_t x_hist [NUM_CH];
  acc_t s_hist [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        x_hist[g] <= '0;
        s_hist[g] <= '0;
      end else if (clr) begin
        x_hist[g] <= '0;
        s_hist[g] <= '0;
      end else if (wr_en && sel_ch == CH_W'(g)) begin
        x_hist[g] <= wr_x;
        s_hist[g] <= wr_s;
      end
    end
  end

  assign rd_x = x_hist[sel_ch];
  assign rd_s = s_hist[sel_ch];
endmodule

// File: rtl/hpf_core.sv
module hpf_core
  import hpf_pkg::*;
#(
  parameter logic [COEF_W-1:0] COEF = COEF_DEF
) (
  input  logic mode_en,
  input  smp_t x_in,
  input  smp_t x_prev,
  input  acc_t s_prev,
  output acc_t s_next,
  output smp_t y_out
);
  acc_t s_calc;
  always_comb begin
    s_calc = next_state(x_in, x_prev, s_prev, COEF);
    s_next = s_calc;
    y_out  = mode_en ? state_to_out(s_calc) : x_in;
  end
endmodule

// File: rtl/dc_block_hpf.sv
module dc_block_hpf
  import hpf_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter logic [COEF_W-1:0] COEF = COEF_DEF,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pwr_dn_n,
  input  logic                    hpf_en_req,
  input  logic                    in_valid,
  input  logic signed [SMP_W-1:0] in_data,
  output logic                    out_valid,
  output logic [CH_W-1:0]         out_ch,
  output logic signed [SMP_W-1:0] out_data
);
  logic            mode_en;
  logic [CH_W-1:0] ch_idx;
  logic            take;
  logic            clr;
  smp_t            x_prev, y_calc;
  acc_t            s_prev, s_calc;

  assign clr  = !pwr_dn_n;
  assign take = pwr_dn_n && in_valid;

  hpf_mode_latch u_mode (
    .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n),
    .en_req(hpf_en_req), .mode_en(mode_en)
  );

  hpf_chan_seq #(.NUM_CH(NUM_CH)) u_seq (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(take), .ch_idx(ch_idx)
  );

  hpf_state_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(take && mode_en),
    .sel_ch(ch_idx), .wr_x(in_data), .wr_s(s_calc),
    .rd_x(x_prev), .rd_s(s_prev)
  );

  hpf_core #(.COEF(COEF)) u_core (
    .mode_en(mode_en), .x_in(in_data), .x_prev(x_prev),
    .s_prev(s_prev), .s_next(s_calc), .y_out(y_calc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_ch    <= '0;
      out_data  <= '0;
    end else if (clr) begin
      out_valid <= 1'b0;
      out_ch    <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= take;
      if (take) begin
        out_ch   <= ch_idx;
        out_data <= y_calc;
      end
    end
  end
endmodule

// File: rtl/dc_block_hpf_chk.sv
module dc_block_hpf_chk #(
  parameter int CH_W = 2,
  parameter int SMP_W = 24
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    pwr_dn_n,
  input logic                    in_valid,
  input logic signed [SMP_W-1:0] in_data,
  input logic                    out_valid,
  input logic [CH_W-1:0]         out_ch,
  input logic signed [SMP_W-1:0] out_data,
  input logic                    mode_en,
  input logic [CH_W-1:0]         ch_idx
);
  // R1
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_dn_n |=> (!out_valid && out_data == '0));
  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_dn_n && $past(pwr_dn_n)) |-> $stable(mode_en));
  // R3
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_dn_n && in_valid && !mode_en) |=> (out_data == $past(in_data)));
  // R5
  chan_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_dn_n && in_valid) |=> (out_valid && out_ch == $past(ch_idx)));
  // R5
  chan_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_dn_n |=> (ch_idx == '0));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_dn_n && !in_valid) |=> (!out_valid && $stable(ch_idx)));
endmodule

bind dc_block_hpf dc_block_hpf_chk #(.CH_W(CH_W), .SMP_W(hpf_pkg::SMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n), .in_valid(in_valid),
  .in_data(in_data), .out_valid(out_valid), .out_ch(out_ch),
  .out_data(out_data), .mode_en(mode_en), .ch_idx(ch_idx)
);

// File: tb/dc_block_hpf_bench.sv
module dc_block_hpf_bench;
  localparam int CLK_P = 10;
  localparam longint A_Q = 16775020;

  logic clk = 1'b0;
  logic rst_n, pwr_dn_n, hpf_en_req, in_valid;
  logic signed [23:0] in_data;
  logic out_valid;
  logic [1:0] out_ch;
  logic signed [23:0] out_data;

  int total = 0, bad = 0;
  longint xp_m [4];
  longint s_m [4];
  int ch_m;
  bit mode_m;

  always #(CLK_P/2) clk = ~clk;

  dc_block_hpf u_dc_block_hpf (
    .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n), .hpf_en_req(hpf_en_req),
    .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid),
    .out_ch(out_ch), .out_data(out_data)
  );

  function automatic longint lim(longint v, int bits);
    longint top = (longint'(1) <<< (bits-1)) - 1;
    longint bot = -(longint'(1) <<< (bits-1));
    return (v > top) ? top : ((v < bot) ? bot : v);
  endfunction

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 4; i++) begin xp_m[i] = 0; s_m[i] = 0; end
    ch_m = 0;
  endtask

  // drive one cycle at a falling edge, check the result one edge later
  task automatic step(bit v, longint x, string req);
    longint y, t;
    in_valid = v;
    in_data  = 24'(x);
    @(posedge clk);
    @(negedge clk);
    if (!pwr_dn_n) begin
      chk("R1 valid", out_valid, 0);
      chk("R1 data", out_data, 0);
    end else if (!v) begin
      chk("R9 idle", out_valid, 0);
    end else begin
      if (mode_m) begin
        t = lim((x - xp_m[ch_m]) * 256 + ((A_Q * s_m[ch_m] + (longint'(1) <<< 23)) >>> 24), 34);
        y = lim((t + 128) >>> 8, 24);
        xp_m[ch_m] = x;
        s_m[ch_m]  = t;
      end else begin
        y = x;
      end
      chk({req, " valid"}, out_valid, 1);
      chk("R5 channel", out_ch, ch_m);
      chk(req, out_data, y);
      ch_m = (ch_m + 1) % 4;
    end
  endtask

  // power-down with a mode request; flip the request as power-down lifts
  task automatic power_cycle(bit en);
    pwr_dn_n   = 1'b0;
    hpf_en_req = en;
    step(1'b1, 1234, "R1");
    step(1'b1, -77, "R1");
    clear_model();
    mode_m     = en;
    pwr_dn_n   = 1'b1;
    hpf_en_req = !en;
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint v;
    void'($urandom(32'd4242));
    rst_n = 1'b0; pwr_dn_n = 1'b0; hpf_en_req = 1'b0;
    in_valid = 1'b0; in_data = '0;
    clear_model(); mode_m = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", out_valid, 0);
    chk("R1 reset data", out_data, 0);
    rst_n = 1'b1;

    // bypass with random gaps; request flips while running (R2, R3)
    power_cycle(1'b0);
    for (int i = 0; i < 60; i++) begin
      if (i == 20) hpf_en_req = 1'b1;
      v = longint'($signed(24'($urandom)));
      step(($urandom % 4) != 0, v, "R3 bypass");
    end

    // filtered with DC offset plus noise; request flips mid-stream (R2, R4, R6)
    power_cycle(1'b1);
    for (int i = 0; i < 800; i++) begin
      if (i == 300) hpf_en_req = 1'b0;
      v = 500000 + longint'($signed(16'($urandom)));
      step(($urandom % 5) != 0, v, "R4 filtered");
    end

    // power-down while a sample is strobed, then cleared history (R8, R9)
    pwr_dn_n = 1'b0; hpf_en_req = 1'b1;
    step(1'b1, 999, "R9");
    clear_model(); mode_m = 1'b1;
    pwr_dn_n = 1'b1;
    step(1'b1, 3000000, "R8 first");
    chk("R8 first equals input", out_data, 3000000);
    // per-channel independence: channel 1 sees nothing of channel 0 (R6)
    step(1'b1, 5, "R6 independent");
    chk("R6 channel 1 value", out_data, 5);
    step(1'b1, 0, "R4");
    step(1'b1, 0, "R4");

    // full-scale steps drive saturation (R7)
    power_cycle(1'b1);
    for (int i = 0; i < 4; i++) step(1'b1, -8388608, "R7 low");
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 8388607, "R7 high");
      chk("R7 clamp top", out_data, 8388607);
    end
    for (int i = 0; i < 4; i++) begin
      step(1'b1, -8388608, "R7 down");
      chk("R7 clamp bottom", out_data, -8388608);
    end
    for (int i = 0; i < 200; i++) begin
      v = ($urandom % 2) ? 8388607 : -8388608;
      step(1'b1, v, "R7 random");
    end

    // back to bypass to confirm the mode follows the next power-down (R2)
    power_cycle(1'b0);
    for (int i = 0; i < 40; i++) begin
      v = longint'($signed(24'($urandom)));
      step(1'b1, v, "R2 bypass again");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule